// File: doc/BRIEF.md
# Serial Display Link Low-Power Lane Sequencer

This block steps the lanes of a serial display link into and out of the ultra-low-power lane state in a fixed order. It drives one request line per lane (one clock lane, up to two data lanes) and watches a 2-bit status code per lane coming back from the physical layer. Data lanes are always handled before the clock lane. Each wait is polled at a coarse interval and gives up after a bounded number of attempts. A timeout flag records any wait that gave up, and the sequence still moves on.

Four commands are accepted while idle: enter low power, leave low power, bring the link up and take the link down. Bringing the link up asserts the link enable first. If any lane still reports low power, the high-speed clock source is switched to the system clock for the wake-up and switched back afterwards. Taking the link down waits until the link has stopped transmitting. It runs the entry sequence only when the suspend qualifier is set, and then drops the link enable. The wake-up time value for both lane kinds is presented as a constant output.

Top module: `lane_ulp_seq`

## Requirements
- R1: After reset all three lane requests, `link_en`, `hs_clk_sel`, `busy`, `done` and `timeout` are 0. `clk_wake_time` and `dat_wake_time` both read 0x1FF.
- R2: Lane status codes are 0 start, 1 idle, 2 write, 3 low power. Command `cmd_op`=0 (enter) raises the requests of the active data lanes first. The clock-lane request rises only after every active data lane has reported 3, or after that wait has given up.
- R3: The second data lane is active only when `two_lanes`=1 and `lane_en[2]`=1. When `two_lanes`=0 its request never rises and its status has no effect on the entry or exit waits.
- R4: Command `cmd_op`=1 (exit) lowers the data-lane requests first and the clock-lane request afterwards. Each lane waits for status 1 (idle).
- R5: Status is sampled on the first cycle of each wait and then once every `TICK_DIV` cycles. If it is still wrong at the `MAX_RETRY`-th interval, `timeout` is set and the sequence goes on to the next step. With all lanes enabled and data lane 1 stuck, the clock request rises exactly `MAX_RETRY*TICK_DIV` cycles after `busy` rises. `timeout` holds until the next command is accepted, which clears it.
- R6: Command `cmd_op`=2 (link up) sets `link_en`. If any of the three status inputs reads 3, `hs_clk_sel` goes to 1 while the exit sequence runs and returns to 0 afterwards. Otherwise `hs_clk_sel` never rises. `hs_clk_sel` is only ever 1 while `link_en` is 1.
- R7: Command `cmd_op`=3 (link down) waits while `link_idle`=0, keeping `link_en` at 1. When `suspend`=1 it then runs the entry sequence. Finally it clears `link_en`. When `suspend`=0 the lane requests are left unchanged.
- R8: A command presented while `busy`=1 is ignored. It changes neither the outcome of the running sequence nor causes any later activity.
- R9: `busy` is 1 from the cycle after a command is accepted until the sequence ends. `done` is a single-cycle pulse at the end of every sequence, whether or not it timed out. `busy` is 0 in the next cycle.
- R10: A lane whose `lane_en` bit is 0 (bit 0 clock, bit 1 data lane 1, bit 2 data lane 2) is skipped. Its request stays 0 and its status has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 enter, 1 exit, 2 link up, 3 link down |
| suspend | input | 1 | Run entry sequence on link down |
| two_lanes | input | 1 | Two data lanes configured |
| lane_en | input | 3 | Per-lane enable: bit0 clock, bit1 data 1, bit2 data 2 |
| link_idle | input | 1 | Link has stopped transmitting |
| clk_lane_st | input | 2 | Clock lane status code |
| dat1_lane_st | input | 2 | Data lane 1 status code |
| dat2_lane_st | input | 2 | Data lane 2 status code |
| clk_ulpm_req | output | 1 | Clock lane low-power request |
| dat1_ulpm_req | output | 1 | Data lane 1 low-power request |
| dat2_ulpm_req | output | 1 | Data lane 2 low-power request |
| hs_clk_sel | output | 1 | High-speed clock source: 1 system clock, 0 byte clock |
| link_en | output | 1 | Link enable |
| clk_wake_time | output | 9 | Clock lane wake-up time value |
| dat_wake_time | output | 9 | Data lane wake-up time value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | A wait gave up during the last sequence |

## Verification
A corrupted sequencer state shows at the lane request pins as an ordering fault: the clock request moves while a data request still lacks its acknowledged status. This appears on the very edge where the clock request changes. A wrong retry or interval count shows as a clock-request edge that lands earlier or later than `MAX_RETRY*TICK_DIV` cycles after `busy`, so a stuck-lane run pins it to the exact cycle. A lost link or clock-select state shows as `hs_clk_sel` without `link_en`, or as `link_en` dropping before `link_idle`. Either appears within one sequence.

// File: rtl/ulpm_pkg.sv
package ulpm_pkg;

    typedef enum logic [1:0] {
        LS_START = 2'd0,
        LS_IDLE  = 2'd1,
        LS_WRITE = 2'd2,
        LS_ULPM  = 2'd3
    } lane_st_e;

    typedef enum logic [1:0] {
        OP_ENTER     = 2'd0,
        OP_EXIT      = 2'd1,
        OP_LINK_UP   = 2'd2,
        OP_LINK_DOWN = 2'd3
    } seq_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_QUIET,
        S_CHECK,
        S_DWAIT,
        S_CWAIT,
        S_RESTORE,
        S_LINK_OFF,
        S_DONE
    } seq_st_e;

    localparam int          WAKE_W   = 9;
    localparam logic [WAKE_W-1:0] WAKE_VAL = 9'h1FF;

    function automatic lane_st_e goal_state(input logic to_ulpm);
        return to_ulpm ? LS_ULPM : LS_IDLE;
    endfunction

    function automatic logic lane_ok(input logic active, input logic [1:0] st,
                                     input logic to_ulpm);
        return !active || (st == goal_state(to_ulpm));
    endfunction

endpackage

// File: rtl/ulpm_wait_timer.sv
module ulpm_wait_timer #(
    parameter int TICK_DIV  = 125000,
    parameter int MAX_RETRY = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic sample,
    output logic expire
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int RW = $clog2(MAX_RETRY + 1);

    logic [CW-1:0] cnt;
    logic [RW-1:0] retry;
    logic          fresh;
    logic          tick;

    assign tick   = run && (cnt == CW'(TICK_DIV - 1));
    assign expire = tick && (retry == RW'(MAX_RETRY - 1));
    assign sample = run && (fresh || tick);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            retry <= '0;
            fresh <= 1'b0;
        end else if (restart) begin
            cnt   <= '0;
            retry <= '0;
            fresh <= 1'b1;
        end else if (run) begin
            fresh <= 1'b0;
            if (tick) begin
                cnt   <= '0;
                retry <= retry + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_retry_bound_r5: assert property (@(posedge clk) disable iff (rst)
        run |-> (retry < RW'(MAX_RETRY)));

endmodule

// File: rtl/ulpm_lane_eval.sv
module ulpm_lane_eval
    import ulpm_pkg::*;
#(
    parameter int N_DATA = 2
) (
    input  logic [N_DATA-1:0][1:0] data_st,
    input  logic [N_DATA-1:0]      data_act,
    input  logic [1:0]             clk_st,
    input  logic                   clk_act,
    input  logic                   to_ulpm,
    output logic                   data_ok,
    output logic                   clk_ok,
    output logic                   any_ulpm
);
    logic [N_DATA-1:0] ok_v;
    logic [N_DATA-1:0] lp_v;

    generate
        for (genvar g = 0; g < N_DATA; g++) begin : g_lane
            assign ok_v[g] = lane_ok(data_act[g], data_st[g], to_ulpm);
            assign lp_v[g] = (data_st[g] == LS_ULPM);
        end
    endgenerate

    assign data_ok  = &ok_v;
    assign clk_ok   = lane_ok(clk_act, clk_st, to_ulpm);
    assign any_ulpm = (|lp_v) || (clk_st == LS_ULPM);

endmodule

// File: rtl/lane_ulp_seq.sv
module lane_ulp_seq
    import ulpm_pkg::*;
#(
    parameter int TICK_DIV  = 125000,
    parameter int MAX_RETRY = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic        suspend,
    input  logic        two_lanes,
    input  logic [2:0]  lane_en,
    input  logic        link_idle,
    input  logic [1:0]  clk_lane_st,
    input  logic [1:0]  dat1_lane_st,
    input  logic [1:0]  dat2_lane_st,
    output logic        clk_ulpm_req,
    output logic        dat1_ulpm_req,
    output logic        dat2_ulpm_req,
    output logic        hs_clk_sel,
    output logic        link_en,
    output logic [8:0]  clk_wake_time,
    output logic [8:0]  dat_wake_time,
    output logic        busy,
    output logic        done,
    output logic        timeout
);
    localparam int N_DATA = 2;

    seq_st_e            st;
    seq_op_e            op_q;
    logic               to_ulpm;
    logic [N_DATA-1:0]  dreq;
    logic               creq;
    logic               hs_q;
    logic               len_q;
    logic               tmo_q;

    logic [N_DATA-1:0]  data_act;
    logic               data_ok, clk_ok, any_ulpm;
    logic               sample, expire, restart, run;
    logic               leave_d, leave_c;
    logic [N_DATA-1:0][1:0] dstat;

    assign data_act = {lane_en[2] & two_lanes, lane_en[1]};
    assign dstat    = {dat2_lane_st, dat1_lane_st};

    ulpm_lane_eval #(.N_DATA(N_DATA)) u_eval (
        .data_st  (dstat),
        .data_act (data_act),
        .clk_st   (clk_lane_st),
        .clk_act  (lane_en[0]),
        .to_ulpm  (to_ulpm),
        .data_ok  (data_ok),
        .clk_ok   (clk_ok),
        .any_ulpm (any_ulpm)
    );

    assign run     = (st == S_DWAIT) || (st == S_CWAIT);
    assign leave_d = (st == S_DWAIT) && ((sample && data_ok) || expire);
    assign leave_c = (st == S_CWAIT) && ((sample && clk_ok) || expire);

    always_comb begin
        restart = 1'b0;
        case (st)
            S_IDLE:  restart = cmd_valid && (cmd_op == OP_ENTER || cmd_op == OP_EXIT);
            S_CHECK: restart = any_ulpm;
            S_QUIET: restart = link_idle && suspend;
            S_DWAIT: restart = leave_d;
            default: restart = 1'b0;
        endcase
    end

    ulpm_wait_timer #(.TICK_DIV(TICK_DIV), .MAX_RETRY(MAX_RETRY)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (run),
        .sample  (sample),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            op_q    <= OP_ENTER;
            to_ulpm <= 1'b0;
            dreq    <= '0;
            creq    <= 1'b0;
            hs_q    <= 1'b0;
            len_q   <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (cmd_valid) begin
                        tmo_q <= 1'b0;
                        op_q  <= seq_op_e'(cmd_op);
                        case (seq_op_e'(cmd_op))
                            OP_ENTER: begin
                                to_ulpm <= 1'b1;
                                dreq    <= data_act;
                                st      <= S_DWAIT;
                            end
                            OP_EXIT: begin
                                to_ulpm <= 1'b0;
                                dreq    <= '0;
                                st      <= S_DWAIT;
                            end
                            OP_LINK_UP: begin
                                len_q <= 1'b1;
                                st    <= S_CHECK;
                            end
                            default: st <= S_QUIET;
                        endcase
                    end
                end
                S_CHECK: begin
                    if (any_ulpm) begin
                        hs_q    <= 1'b1;
                        to_ulpm <= 1'b0;
                        dreq    <= '0;
                        st      <= S_DWAIT;
                    end else begin
                        st <= S_DONE;
                    end
                end
                S_QUIET: begin
                    if (link_idle) begin
                        if (suspend) begin
                            to_ulpm <= 1'b1;
                            dreq    <= data_act;
                            st      <= S_DWAIT;
                        end else begin
                            st <= S_LINK_OFF;
                        end
                    end
                end
                S_DWAIT: begin
                    if (leave_d) begin
                        if (expire && !data_ok) tmo_q <= 1'b1;
                        creq <= to_ulpm & lane_en[0];
                        st   <= S_CWAIT;
                    end
                end
                S_CWAIT: begin
                    if (leave_c) begin
                        if (expire && !clk_ok) tmo_q <= 1'b1;
                        case (op_q)
                            OP_LINK_UP:   st <= S_RESTORE;
                            OP_LINK_DOWN: st <= S_LINK_OFF;
                            default:      st <= S_DONE;
                        endcase
                    end
                end
                S_RESTORE: begin
                    hs_q <= 1'b0;
                    st   <= S_DONE;
                end
                S_LINK_OFF: begin
                    len_q <= 1'b0;
                    st    <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign dat1_ulpm_req = dreq[0];
    assign dat2_ulpm_req = dreq[1];
    assign clk_ulpm_req  = creq;
    assign hs_clk_sel    = hs_q;
    assign link_en       = len_q;
    assign timeout       = tmo_q;
    assign busy          = (st != S_IDLE);
    assign done          = (st == S_DONE);
    assign clk_wake_time = WAKE_VAL;
    assign dat_wake_time = WAKE_VAL;

    // R2: clock request rises only once the active data lanes reached low power
    p_clk_after_data_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_ulpm_req) |-> (timeout ||
            ((!dat1_ulpm_req || $past(dat1_lane_st) == LS_ULPM) &&
             (!dat2_ulpm_req || $past(dat2_lane_st) == LS_ULPM))));

    p_d2_two_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(dat2_ulpm_req) |-> $past(two_lanes));

    p_exit_order_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_ulpm_req) |-> (!dat1_ulpm_req && !dat2_ulpm_req));

    p_hs_link_r6: assert property (@(posedge clk) disable iff (rst)
        hs_clk_sel |-> link_en);

    p_hs_restore_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_clk_sel) |-> (!clk_ulpm_req && !dat1_ulpm_req && !dat2_ulpm_req));

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && cmd_valid) |=> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_clk_en_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_ulpm_req) |-> $past(lane_en[0]));

endmodule

// File: tb/test_lane_ulp_seq.sv
module test_lane_ulp_seq;
    localparam int DIV  = 6;
    localparam int MAXR = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic       suspend = 1'b0;
    logic       two_lanes = 1'b1;
    logic [2:0] lane_en = 3'b111;
    logic       link_idle = 1'b1;
    logic [1:0] ls [3];
    logic       clk_ulpm_req, dat1_ulpm_req, dat2_ulpm_req;
    logic       hs_clk_sel, link_en, busy, done, timeout;
    logic [8:0] clk_wake_time, dat_wake_time;

    always #4 clk = ~clk;

    lane_ulp_seq #(.TICK_DIV(DIV), .MAX_RETRY(MAXR)) i_lane_ulp_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .suspend(suspend), .two_lanes(two_lanes), .lane_en(lane_en),
        .link_idle(link_idle), .clk_lane_st(ls[0]), .dat1_lane_st(ls[1]),
        .dat2_lane_st(ls[2]), .clk_ulpm_req(clk_ulpm_req),
        .dat1_ulpm_req(dat1_ulpm_req), .dat2_ulpm_req(dat2_ulpm_req),
        .hs_clk_sel(hs_clk_sel), .link_en(link_en),
        .clk_wake_time(clk_wake_time), .dat_wake_time(dat_wake_time),
        .busy(busy), .done(done), .timeout(timeout));

    // lane model: index 0 clock, 1 data 1, 2 data 2
    int   lat [3];
    logic stuck [3];
    int   lcnt [3];
    logic [2:0] reqv;
    assign reqv = {dat2_ulpm_req, dat1_ulpm_req, clk_ulpm_req};

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (rst) begin
                ls[i]   <= 2'd0;
                lcnt[i] <= 0;
            end else if (!stuck[i]) begin
                if (ls[i] != (reqv[i] ? 2'd3 : 2'd1)) begin
                    if (lcnt[i] >= lat[i]) begin
                        ls[i]   <= reqv[i] ? 2'd3 : 2'd1;
                        lcnt[i] <= 0;
                    end else begin
                        lcnt[i] <= lcnt[i] + 1;
                    end
                end else begin
                    lcnt[i] <= 0;
                end
            end
        end
    end

    // monitor
    logic mon_clr = 1'b0;
    int   cyc = 0;
    int   rise_t [3];
    int   fall_t [3];
    int   busy_t;
    logic hs_seen;
    logic prev_r [3];
    logic prev_busy;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clr) begin
            for (int i = 0; i < 3; i++) begin
                rise_t[i] = -1;
                fall_t[i] = -1;
            end
            busy_t  = -1;
            hs_seen = 1'b0;
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (reqv[i] && !prev_r[i]) rise_t[i] = cyc;
                if (!reqv[i] && prev_r[i]) fall_t[i] = cyc;
            end
            if (busy && !prev_busy) busy_t = cyc;
            if (hs_clk_sel) hs_seen = 1'b1;
        end
        for (int i = 0; i < 3; i++) prev_r[i] = reqv[i];
        prev_busy = busy;
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        mon_clr = 1'b1;
        @(posedge clk);
        mon_clr = 1'b0;
    endtask

    function automatic logic lane_fail(input int i, input logic active, input logic to_lp);
        return active && stuck[i] && (ls[i] != (to_lp ? 2'd3 : 2'd1));
    endfunction

    function automatic logic exp_tmo(input logic to_lp);
        return lane_fail(0, lane_en[0], to_lp) || lane_fail(1, lane_en[1], to_lp) ||
               lane_fail(2, lane_en[2] & two_lanes, to_lp);
    endfunction

    task automatic run_cmd(input logic [1:0] op, input bit inject);
        bit seen;
        clear_mon();
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 busy after accept", busy, 1);
        chk("R5 timeout cleared on accept", timeout, 0);
        if (inject) begin
            cmd_valid = 1'b1;
            cmd_op    = op ^ 2'd1;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        seen = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk("R9 done pulse seen", seen, 1);
        @(negedge clk);
        chk("R9 done lasts one cycle", done, 0);
        chk("R9 busy low after done", busy, 0);
        @(negedge clk);
    endtask

    task automatic chk_reqs(input string tag, input logic c, input logic d1, input logic d2);
        chk({tag, " clk req"}, clk_ulpm_req, c);
        chk({tag, " dat1 req"}, dat1_ulpm_req, d1);
        chk({tag, " dat2 req"}, dat2_ulpm_req, d2);
    endtask

    task automatic chk_order(input string tag, input bit rising);
        for (int i = 1; i < 3; i++) begin
            if (rising && rise_t[0] >= 0 && rise_t[i] >= 0)
                chk({tag, " clk after data"}, int'(rise_t[0] > rise_t[i]), 1);
            if (!rising && fall_t[0] >= 0 && fall_t[i] >= 0)
                chk({tag, " clk after data"}, int'(fall_t[0] > fall_t[i]), 1);
        end
    endtask

    task automatic set_lanes(input int l0, input int l1, input int l2,
                             input logic s0, input logic s1, input logic s2);
        @(negedge clk);
        lat[0] = l0; lat[1] = l1; lat[2] = l2;
        stuck[0] = s0; stuck[1] = s1; stuck[2] = s2;
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic t_exp;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin
            lat[i] = 1;
            stuck[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk_reqs("R1", 0, 0, 0);
        chk("R1 link_en", link_en, 0);
        chk("R1 hs_clk_sel", hs_clk_sel, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 timeout", timeout, 0);
        chk("R1 clk wake", clk_wake_time, 9'h1FF);
        chk("R1 dat wake", dat_wake_time, 9'h1FF);
        repeat (5) @(negedge clk);

        // R6: link up with no lane in low power
        run_cmd(2'd2, 0);
        chk("R6 link_en set", link_en, 1);
        chk("R6 no clock swap", hs_seen, 0);

        // R2: entry with all lanes
        set_lanes(1, 3, 2, 0, 0, 0);
        run_cmd(2'd0, 0);
        chk_reqs("R2 enter", 1, 1, 1);
        chk("R2 no timeout", timeout, 0);
        chk_order("R2", 1);

        // R7: link down without suspend waits for quiet link
        link_idle = 1'b0;
        clear_mon();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk("R7 busy while link active", busy, 1);
        chk("R7 link_en held", link_en, 1);
        link_idle = 1'b1;
        for (int k = 0; k < 50; k++) begin
            if (done) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk("R7 link_en cleared", link_en, 0);
        chk_reqs("R7 no suspend keeps reqs", 1, 1, 1);

        // R6: link up with lanes in low power
        run_cmd(2'd2, 0);
        chk("R6 clock swapped", hs_seen, 1);
        chk("R6 clock restored", hs_clk_sel, 0);
        chk("R6 link_en", link_en, 1);
        chk_reqs("R6 woken", 0, 0, 0);
        chk_order("R6", 0);

        // R7: link down with suspend enters low power
        suspend = 1'b1;
        run_cmd(2'd3, 0);
        chk("R7 link_en off", link_en, 0);
        chk_reqs("R7 suspend entry", 1, 1, 1);
        suspend = 1'b0;

        // R4: exit
        run_cmd(2'd1, 0);
        chk_reqs("R4 exit", 0, 0, 0);
        chk_order("R4", 0);
        chk("R4 lane idle", ls[0], 1);

        // R8: command while busy ignored
        set_lanes(4, 4, 4, 0, 0, 0);
        run_cmd(2'd0, 1);
        chk_reqs("R8 enter unaffected", 1, 1, 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R8 no further activity", busy, 0);
        end
        run_cmd(2'd1, 0);

        // R5: stuck data lane 1 -> timeout after MAXR*DIV cycles
        set_lanes(1, 1, 1, 0, 1, 0);
        run_cmd(2'd0, 0);
        chk("R5 timeout set", timeout, 1);
        chk("R5 interval count", rise_t[0] - busy_t, MAXR * DIV);
        chk("R5 sequence continued", clk_ulpm_req, 1);
        repeat (5) @(negedge clk);
        chk("R5 timeout held", timeout, 1);
        set_lanes(1, 1, 1, 0, 0, 0);
        run_cmd(2'd1, 0);
        chk("R5 cleared by next command", timeout, 0);

        // R3: single lane, lane 2 stuck but ignored
        two_lanes = 1'b0;
        set_lanes(1, 1, 1, 0, 0, 1);
        run_cmd(2'd0, 0);
        chk("R3 dat2 req low", dat2_ulpm_req, 0);
        chk("R3 dat2 status ignored", timeout, 0);
        run_cmd(2'd1, 0);
        two_lanes = 1'b1;

        // R10: disabled clock lane skipped
        lane_en = 3'b110;
        set_lanes(1, 1, 1, 1, 0, 0);
        run_cmd(2'd0, 0);
        chk_reqs("R10 clock skipped", 0, 1, 1);
        chk("R10 clock status ignored", timeout, 0);
        run_cmd(2'd1, 0);
        lane_en = 3'b111;
        set_lanes(1, 1, 1, 0, 0, 0);
        repeat (10) @(negedge clk);

        // random pairs of entry and exit
        for (int it = 0; it < 16; it++) begin
            @(negedge clk);
            lane_en   = 3'($urandom_range(0, 7));
            two_lanes = 1'($urandom_range(0, 1));
            set_lanes($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
                      ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                      ($urandom_range(0, 5) == 0));
            repeat (8) @(negedge clk);
            t_exp = exp_tmo(1'b1);
            run_cmd(2'd0, 0);
            chk_reqs("R2 R10 random enter", lane_en[0], lane_en[1], lane_en[2] & two_lanes);
            chk("R5 random enter timeout", timeout, t_exp);
            chk_order("R2 random", 1);
            set_lanes($urandom_range(0, 4), $urandom_range(0, 4), $urandom_range(0, 4),
                      ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0),
                      ($urandom_range(0, 5) == 0));
            t_exp = exp_tmo(1'b0);
            run_cmd(2'd1, 0);
            chk_reqs("R4 random exit", 0, 0, 0);
            chk("R5 random exit timeout", timeout, t_exp);
            chk_order("R4 random", 0);
            set_lanes(1, 1, 1, 0, 0, 0);
            repeat (8) @(negedge clk);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule